// File: doc/BRIEF.md
# Four-Way Set-Associative Instruction Cache

This block sits between a 32-bit processor's instruction fetch port and a slower backing memory. It keeps 8 KiB of code as 64 sets, each with four lines of eight 32-bit words. Every fetch address is checked against all four tags of its set at once. On a match, the addressed word is returned in the cycle after the fetch is accepted. On a mismatch, one way of the set is chosen as the victim. The whole line is read from backing memory one word per handshake, the tag is written, and then the requested word is returned.

Victim selection has two modes, set by an input. In one mode, a two-bit counter kept for each set steps through the ways in turn. In the other, a shared 32-bit pseudo-random state picks the way. Software maintenance reaches the block through a command strobe with a 12-bit code. One code clears every line. Another clears the single line that holds a given address. A command that arrives while a line is being filled is held in a one-entry slot and carried out once the fill has finished.

Top module: `insn_cache`

## Requirements
- R1: After reset, every tag entry holds the value 1, which no fetch tag can equal. resp_valid and mem_valid are low and fetch_ready is high, and the first fetch to any address misses.
- R2: A fetch hits when the stored tag in one way of its set equals the address with bits [10:0] cleared. The set is given by address bits [10:5]. On a hit, resp_valid and resp_hit are high in the cycle after acceptance, and resp_data is word [4:2] of that line. No backing-memory access is made.
- R3: On a miss, the block makes exactly eight backing-memory reads. They start at the fetch address with bits [4:0] cleared and rise by 4 each time. mem_seq is 0 for the first read and 1 for the other seven. After the last read, resp_valid is high with resp_hit low and resp_data set to the requested word.
- R4: While mem_valid is high and mem_ready is low, mem_valid stays high and mem_addr does not change.
- R5: When repl_rr is 1, the victim way is the set's 2-bit counter. The counter resets to 0 and steps modulo 4 on each miss in that set only. A fifth distinct line in a set therefore replaces the line filled first.
- R6: When repl_rr is 0, each miss draws from a 32-bit state that resets to 44203. The new state is s xor 17*s xor 7*s, where s is the state before the draw. The victim way is bits [18:17] of the new state. Misses taken in round-robin mode do not advance this state.
- R7: A command with code 0x750 sets every tag to 1, so every line fetched before it misses afterwards.
- R8: A command with code 0x751 clears the lowest-numbered way of cmd_data's set whose tag matches cmd_data. Other lines in that set keep hitting.
- R9: Command codes other than 0x750 and 0x751 have no effect on the contents of the cache.
- R10: While a fill is in progress, fetch_ready is low. A command issued during a fill takes effect only after the fill has written its tag and returned its word.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| repl_rr | input | 1 | 1: round-robin victim, 0: pseudo-random victim |
| fetch_valid | input | 1 | Fetch request present |
| fetch_addr | input | 32 | Fetch byte address |
| fetch_ready | output | 1 | Fetch can be accepted this cycle |
| resp_valid | output | 1 | Fetch result valid (one-cycle pulse) |
| resp_hit | output | 1 | Result came from a hit |
| resp_data | output | 32 | Fetched instruction word |
| cmd_valid | input | 1 | Maintenance command strobe |
| cmd_code | input | 12 | Command code (0x750 clear all, 0x751 clear by address) |
| cmd_data | input | 32 | Address operand of the command |
| mem_valid | output | 1 | Backing-memory read request |
| mem_addr | output | 32 | Word address of the read |
| mem_seq | output | 1 | Read is sequential to the previous one |
| mem_ready | input | 1 | Backing memory accepts and returns data this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ready |

## Verification
The bench starts with a line fetched at a mid-line word while the backing memory stalls at intervals. This separates correct burst ordering and address holding from reads that start at the requested word or move on during a stall. Repeat fetches of the same line and of another tag in the same set separate a real tag compare from an index-only compare.

Five and more distinct tags aimed at one set, in each replacement mode, show which way was evicted. Every surviving line is probed for a hit before the evicted one is probed for a miss. The maintenance tests each pair a command with a line that must survive and a line that must not, and send one command in the middle of a fill. These tell whole-cache clearing, single-line clearing, ignored codes and deferred execution apart.

// File: rtl/insn_cache_pkg.sv
package insn_cache_pkg;
  typedef enum logic {ST_IDLE, ST_FILL} ic_state_e;

  localparam logic [11:0] CMD_CLR_ALL  = 12'h750;
  localparam logic [11:0] CMD_CLR_ADDR = 12'h751;
  localparam logic [31:0] TAG_EMPTY    = 32'd1;
  localparam logic [31:0] RNG_INIT     = 32'd44203;
  localparam int          RNG_TAP      = 17;

  // one draw of the victim generator
  function automatic logic [31:0] rng_next(input logic [31:0] s);
    return s ^ (s * 32'd17) ^ (s * 32'd7);
  endfunction

  // stored tag: address with offset and index bits cleared
  function automatic logic [31:0] tag_of(input logic [31:0] a, input int lsb);
    return a & ~((32'd1 << lsb) - 32'd1);
  endfunction
endpackage

// File: rtl/insn_cache_tags.sv
module insn_cache_tags
  import insn_cache_pkg::*;
#(
  parameter int SET_BITS  = 6,
  parameter int WAY_BITS  = 2,
  parameter int WORD_BITS = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [31:0]         look_addr,
  output logic                hit,
  output logic [WAY_BITS-1:0] hit_way,
  output logic [(1<<WAY_BITS)-1:0] hit_vec,
  input  logic                clr_all,
  input  logic                clr_one,
  input  logic [31:0]         clr_addr,
  input  logic                wr_en,
  input  logic [31:0]         wr_addr,
  input  logic [WAY_BITS-1:0] wr_way
);
  localparam int WAYS    = 1 << WAY_BITS;
  localparam int ENTRIES = (1 << SET_BITS) * WAYS;
  localparam int OFF     = WORD_BITS + 2;
  localparam int TAG_LSB = OFF + SET_BITS;

  logic [31:0] tag_q [ENTRIES];

  logic [SET_BITS-1:0] look_set, clr_set, wr_set;
  logic [WAYS-1:0]     clr_vec;
  logic [WAY_BITS-1:0] clr_way;

  assign look_set = look_addr[OFF +: SET_BITS];
  assign clr_set  = clr_addr[OFF +: SET_BITS];
  assign wr_set   = wr_addr[OFF +: SET_BITS];

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    localparam logic [WAY_BITS-1:0] WID = WAY_BITS'(w);
    assign hit_vec[w] = tag_q[{look_set, WID}] == tag_of(look_addr, TAG_LSB);
    assign clr_vec[w] = tag_q[{clr_set, WID}]  == tag_of(clr_addr, TAG_LSB);
  end

  // lowest matching way wins
  always_comb begin
    hit_way = '0;
    clr_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) hit_way = WAY_BITS'(w);
      if (clr_vec[w]) clr_way = WAY_BITS'(w);
    end
  end

  assign hit = |hit_vec;

  always_ff @(posedge clk) begin
    if (!rst_n || clr_all) begin
      for (int i = 0; i < ENTRIES; i++) tag_q[i] <= TAG_EMPTY;
    end else begin
      if (wr_en) tag_q[{wr_set, wr_way}] <= tag_of(wr_addr, TAG_LSB);
      if (clr_one && |clr_vec) tag_q[{clr_set, clr_way}] <= TAG_EMPTY;
    end
  end
endmodule

// File: rtl/insn_cache_data.sv
module insn_cache_data #(
  parameter int SET_BITS  = 6,
  parameter int WAY_BITS  = 2,
  parameter int WORD_BITS = 3
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic [SET_BITS-1:0]  wr_set,
  input  logic [WAY_BITS-1:0]  wr_way,
  input  logic [WORD_BITS-1:0] wr_word,
  input  logic [31:0]          wr_data,
  input  logic [SET_BITS-1:0]  rd_set,
  input  logic [WAY_BITS-1:0]  rd_way,
  input  logic [WORD_BITS-1:0] rd_word,
  output logic [31:0]          rd_data
);
  localparam int DEPTH = 1 << (SET_BITS + WAY_BITS + WORD_BITS);

  logic [31:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[{wr_set, wr_way, wr_word}] <= wr_data;
  end

  assign rd_data = mem_q[{rd_set, rd_way, rd_word}];
endmodule

// File: rtl/insn_cache_victim.sv
module insn_cache_victim
  import insn_cache_pkg::*;
#(
  parameter int SET_BITS = 6,
  parameter int WAY_BITS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                repl_rr,
  input  logic                draw,
  input  logic [SET_BITS-1:0] set,
  output logic [WAY_BITS-1:0] victim
);
  localparam int SETS = 1 << SET_BITS;

  logic [WAY_BITS-1:0] turn_q [SETS];
  logic [31:0]         seed_q, seed_n;

  assign seed_n = rng_next(seed_q);
  assign victim = repl_rr ? turn_q[set] : seed_n[RNG_TAP +: WAY_BITS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SETS; i++) turn_q[i] <= '0;
      seed_q <= RNG_INIT;
    end else if (draw) begin
      if (repl_rr) turn_q[set] <= turn_q[set] + 1'b1;
      else         seed_q      <= seed_n;
    end
  end
endmodule

// File: rtl/insn_cache.sv
module insn_cache
  import insn_cache_pkg::*;
#(
  parameter int SET_BITS  = 6,
  parameter int WAY_BITS  = 2,
  parameter int WORD_BITS = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        repl_rr,
  input  logic        fetch_valid,
  input  logic [31:0] fetch_addr,
  output logic        fetch_ready,
  output logic        resp_valid,
  output logic        resp_hit,
  output logic [31:0] resp_data,
  input  logic        cmd_valid,
  input  logic [11:0] cmd_code,
  input  logic [31:0] cmd_data,
  output logic        mem_valid,
  output logic [31:0] mem_addr,
  output logic        mem_seq,
  input  logic        mem_ready,
  input  logic [31:0] mem_rdata
);
  localparam int OFF  = WORD_BITS + 2;
  localparam int WAYS = 1 << WAY_BITS;

  ic_state_e            state_q;
  logic [31:0]          base_q;
  logic [WORD_BITS-1:0] beat_q, want_q;
  logic [WAY_BITS-1:0]  way_q;
  logic [31:0]          cap_q;
  logic                 pend_q;
  logic [11:0]          pend_code_q;
  logic [31:0]          pend_data_q;
  logic                 resp_valid_q, resp_hit_q;
  logic [31:0]          resp_data_q;

  // named events for the checker
  logic idle, accept, hit_evt, miss_evt, beat_evt, fill_done;
  logic act_valid, clr_all_evt, clr_one_evt;
  logic [11:0] act_code;
  logic [31:0] act_data;

  logic                 hit;
  logic [WAY_BITS-1:0]  hit_way, victim;
  logic [WAYS-1:0]      hit_vec;
  logic [31:0]          rd_data;

  assign idle        = state_q == ST_IDLE;
  assign fetch_ready = idle && !pend_q && !cmd_valid;
  assign accept      = fetch_valid && fetch_ready;
  assign hit_evt     = accept && hit;
  assign miss_evt    = accept && !hit;

  assign mem_valid = state_q == ST_FILL;
  assign mem_addr  = base_q | 32'({beat_q, 2'b00});
  assign mem_seq   = beat_q != '0;
  assign beat_evt  = mem_valid && mem_ready;
  assign fill_done = beat_evt && (beat_q == '1);

  // a held command runs first; a new one waits behind it
  assign act_valid   = idle && (pend_q || cmd_valid);
  assign act_code    = pend_q ? pend_code_q : cmd_code;
  assign act_data    = pend_q ? pend_data_q : cmd_data;
  assign clr_all_evt = act_valid && act_code == CMD_CLR_ALL;
  assign clr_one_evt = act_valid && act_code == CMD_CLR_ADDR;

  insn_cache_tags #(.SET_BITS(SET_BITS), .WAY_BITS(WAY_BITS), .WORD_BITS(WORD_BITS)) u_tags (
    .clk(clk), .rst_n(rst_n), .look_addr(fetch_addr),
    .hit(hit), .hit_way(hit_way), .hit_vec(hit_vec),
    .clr_all(clr_all_evt), .clr_one(clr_one_evt), .clr_addr(act_data),
    .wr_en(fill_done), .wr_addr(base_q), .wr_way(way_q)
  );

  insn_cache_data #(.SET_BITS(SET_BITS), .WAY_BITS(WAY_BITS), .WORD_BITS(WORD_BITS)) u_data (
    .clk(clk), .wr_en(beat_evt),
    .wr_set(base_q[OFF +: SET_BITS]), .wr_way(way_q), .wr_word(beat_q), .wr_data(mem_rdata),
    .rd_set(fetch_addr[OFF +: SET_BITS]), .rd_way(hit_way), .rd_word(fetch_addr[2 +: WORD_BITS]),
    .rd_data(rd_data)
  );

  insn_cache_victim #(.SET_BITS(SET_BITS), .WAY_BITS(WAY_BITS)) u_victim (
    .clk(clk), .rst_n(rst_n), .repl_rr(repl_rr), .draw(miss_evt),
    .set(fetch_addr[OFF +: SET_BITS]), .victim(victim)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      base_q       <= '0;
      beat_q       <= '0;
      want_q       <= '0;
      way_q        <= '0;
      cap_q        <= '0;
      pend_q       <= 1'b0;
      pend_code_q  <= '0;
      pend_data_q  <= '0;
      resp_valid_q <= 1'b0;
      resp_hit_q   <= 1'b0;
      resp_data_q  <= '0;
    end else begin
      resp_valid_q <= hit_evt || fill_done;
      resp_hit_q   <= hit_evt;
      if (hit_evt) resp_data_q <= rd_data;
      else if (fill_done) resp_data_q <= (beat_q == want_q) ? mem_rdata : cap_q;

      if (miss_evt) begin
        state_q <= ST_FILL;
        base_q  <= {fetch_addr[31:OFF], OFF'(0)};
        want_q  <= fetch_addr[2 +: WORD_BITS];
        way_q   <= victim;
        beat_q  <= '0;
      end else if (beat_evt) begin
        if (beat_q == want_q) cap_q <= mem_rdata;
        beat_q <= beat_q + 1'b1;
        if (fill_done) state_q <= ST_IDLE;
      end

      if (cmd_valid && (!idle || pend_q)) begin
        pend_q      <= 1'b1;
        pend_code_q <= cmd_code;
        pend_data_q <= cmd_data;
      end else if (idle) begin
        pend_q <= 1'b0;
      end
    end
  end

  assign resp_valid = resp_valid_q;
  assign resp_hit   = resp_hit_q;
  assign resp_data  = resp_data_q;
endmodule

// File: rtl/insn_cache_chk.sv
module insn_cache_chk #(
  parameter int WAY_BITS = 2
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      hit_evt,
  input logic                      miss_evt,
  input logic                      fill_done,
  input logic                      clr_all_evt,
  input logic [(1<<WAY_BITS)-1:0]  hit_vec,
  input logic                      fetch_ready,
  input logic                      mem_valid,
  input logic                      mem_ready,
  input logic [31:0]               mem_addr,
  input logic                      mem_seq,
  input logic                      resp_valid,
  input logic                      resp_hit
);
  assert_hit_resp_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit_evt |=> resp_valid && resp_hit);

  assert_one_way_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  assert_fill_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    miss_evt |=> mem_valid && !mem_seq);

  assert_fill_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && mem_ready && !fill_done |=> mem_valid && mem_seq && mem_addr == $past(mem_addr) + 32'd4);

  assert_fill_resp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_done |=> resp_valid && !resp_hit);

  assert_mem_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr));

  assert_clear_miss_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all_evt |=> !hit_evt);

  assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> !fetch_ready);
endmodule

bind insn_cache insn_cache_chk #(.WAY_BITS(WAY_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .hit_evt(hit_evt), .miss_evt(miss_evt),
  .fill_done(fill_done), .clr_all_evt(clr_all_evt), .hit_vec(hit_vec),
  .fetch_ready(fetch_ready), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_seq(mem_seq), .resp_valid(resp_valid), .resp_hit(resp_hit)
);

// File: tb/insn_cache_test.sv
`timescale 1ns/1ps
module insn_cache_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        repl_rr = 1'b1;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_addr = '0;
  logic        fetch_ready, resp_valid, resp_hit;
  logic [31:0] resp_data;
  logic        cmd_valid = 1'b0;
  logic [11:0] cmd_code = '0;
  logic [31:0] cmd_data = '0;
  logic        mem_valid, mem_seq;
  logic [31:0] mem_addr, mem_rdata;
  logic        mem_ready = 1'b1;

  int checks = 0, errors = 0, cyc = 0, hs_n = 0;
  logic [31:0] hs_addr [8];
  logic        hs_seq [8];
  bit          done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  insn_cache uut (.*);

  function automatic logic [31:0] mdata(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'h13572468;
  endfunction
  assign mem_rdata = mdata(mem_addr);

  // stall one cycle in three
  always @(negedge clk) begin
    cyc++;
    mem_ready <= (cyc % 3) != 0;
  end

  always @(posedge clk) if (mem_valid && mem_ready) begin
    if (hs_n < 8) begin
      hs_addr[hs_n] = mem_addr;
      hs_seq[hs_n]  = mem_seq;
    end
    hs_n++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] line_addr(input int tag, input int set, input int word);
    return 32'((tag << 11) | (set << 5) | (word << 2));
  endfunction

  task automatic fetch(input logic [31:0] a, output logic [31:0] d, output logic h, output int lat);
    @(negedge clk);
    hs_n = 0;
    fetch_valid = 1'b1;
    fetch_addr  = a;
    while (!fetch_ready) @(negedge clk);
    @(negedge clk);
    fetch_valid = 1'b0;
    lat = 0;
    while (!resp_valid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    d = resp_data;
    h = resp_hit;
  endtask

  task automatic expect_hit(input logic [31:0] a, input string req);
    logic [31:0] d; logic h; int lat;
    fetch(a, d, h, lat);
    chk(h && lat == 0 && hs_n == 0, req, {31'd0, h}, 32'd1);
    chk(d == mdata(a & ~32'd3), req, d, mdata(a & ~32'd3));
  endtask

  task automatic expect_miss(input logic [31:0] a, input string req);
    logic [31:0] d; logic h; int lat;
    fetch(a, d, h, lat);
    chk(!h && hs_n == 8, req, 32'(hs_n), 32'd8);
    chk(d == mdata(a & ~32'd3), req, d, mdata(a & ~32'd3));
  endtask

  task automatic send_cmd(input logic [11:0] code, input logic [31:0] data);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = code; cmd_data = data;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic t_reset();  // R1
    chk(!resp_valid && !mem_valid && fetch_ready, "R1 idle after reset",
        {29'd0, resp_valid, mem_valid, fetch_ready}, 32'd1);
    expect_miss(32'h0000_0000, "R1 first fetch misses");
  endtask

  task automatic t_fill_order();  // R3 R4
    expect_miss(32'h0000_1234, "R3 fill result");
    for (int i = 0; i < 8; i++) begin
      chk(hs_addr[i] == 32'h0000_1220 + 32'(4 * i), "R3 R4 read address", hs_addr[i], 32'h0000_1220 + 32'(4 * i));
      chk(hs_seq[i] == (i != 0), "R3 seq flag", {31'd0, hs_seq[i]}, {31'd0, i != 0});
    end
  endtask

  task automatic t_hit();  // R2
    expect_hit(32'h0000_1234, "R2 same word");
    expect_hit(32'h0000_1220, "R2 other word");
    expect_miss(32'h0000_1A34, "R2 other tag same set");
    expect_hit(32'h0000_1A38, "R2 second tag");
    expect_hit(32'h0000_123C, "R2 first tag kept");
  endtask

  task automatic t_rr();  // R5
    for (int t = 1; t <= 5; t++) expect_miss(line_addr(t, 5, t), "R5 fill");
    for (int t = 2; t <= 5; t++) expect_hit(line_addr(t, 5, 0), "R5 survivor");
    expect_miss(line_addr(1, 5, 0), "R5 oldest evicted");
  endtask

  task automatic t_clr_addr();  // R8 R9
    expect_miss(line_addr(3, 12, 0), "R8 fill a");
    expect_miss(line_addr(4, 12, 0), "R8 fill b");
    send_cmd(12'h751, line_addr(4, 12, 6));
    expect_hit(line_addr(3, 12, 1), "R8 other line kept");
    expect_miss(line_addr(4, 12, 2), "R8 line cleared");
    send_cmd(12'h752, line_addr(3, 12, 0));
    send_cmd(12'h000, line_addr(3, 12, 0));
    expect_hit(line_addr(3, 12, 2), "R9 unknown code ignored");
  endtask

  task automatic t_clr_all();  // R7
    expect_hit(32'h0000_1234, "R7 present before");
    send_cmd(12'h750, 32'h0);
    expect_miss(32'h0000_1234, "R7 cleared a");
    expect_miss(line_addr(5, 5, 0), "R7 cleared b");
  endtask

  task automatic t_defer();  // R10
    int lat = 0;
    @(negedge clk);
    hs_n = 0;
    fetch_valid = 1'b1; fetch_addr = line_addr(7, 20, 3);
    while (!fetch_ready) @(negedge clk);
    @(negedge clk);
    fetch_valid = 1'b0;
    cmd_valid = 1'b1; cmd_code = 12'h750; cmd_data = '0;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!fetch_ready, "R10 busy during fill", {31'd0, fetch_ready}, 32'd0);
    while (!resp_valid && lat < 200) begin @(negedge clk); lat++; end
    chk(resp_valid && !resp_hit && hs_n == 8, "R10 fill finished", 32'(hs_n), 32'd8);
    chk(resp_data == mdata(line_addr(7, 20, 3)), "R10 fill data", resp_data, mdata(line_addr(7, 20, 3)));
    expect_miss(line_addr(7, 20, 3), "R10 held clear ran after fill");
  endtask

  task automatic t_random();  // R6
    logic [31:0] s, n;
    int v;
    for (int t = 1; t <= 4; t++) expect_miss(line_addr(t, 9, 0), "R6 rr prefill");
    repl_rr = 1'b0;
    s = 32'd44203;
    n = s ^ ((s << 4) + s) ^ ((s << 3) - s);
    v = int'(n[18:17]);
    expect_miss(line_addr(9, 9, 0), "R6 random miss");
    for (int w = 0; w < 4; w++)
      if (w != v) expect_hit(line_addr(w + 1, 9, 1), "R6 untouched way");
    expect_miss(line_addr(v + 1, 9, 1), "R6 drawn way evicted");
    repl_rr = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fill_order();
    t_hit();
    t_rr();
    t_clr_addr();
    t_clr_all();
    t_defer();
    t_random();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule